// File: doc/BRIEF.md
# Trace Differential-Address Packet Decoder

This block takes one compressed trace packet per cycle, presented as a little-endian byte string together with a byte count. It rebuilds the full payload by filling every missing upper bit with a copy of the last received bit. It checks the format code in the two lowest bits. For a differential-address packet it then extracts a signed byte difference and three flags.

Each flag is coded relative to the bit beneath it. A flag reads true only when its bit differs from the bit below it. This lets the encoder drop the upper bytes of a packet whenever those bytes merely repeat the sign.

The decoded difference is added to a stored last address. The sum becomes the new absolute address and is written back as the stored address. A load input sets the stored address directly, for example after a synchronisation point.

All results appear on registered outputs one cycle after the packet is presented.

Top module: `trace_diff_decoder`

## Requirements
- R1: After reset, `addr` is 0 and `valid`, `error`, `notify`, `updiscon` and `irreport` are all 0.
- R2: The format code is bits 1:0 of byte 0, and only the value 2'b10 is accepted. For any other code, one cycle later `error` pulses for one cycle, `valid` stays 0 and `addr` is unchanged.
- R3: `pktLen` gives the number of received bytes and must lie between 1 and 9. A length of 0 or above 9 is handled like R2: `error` pulses, `valid` stays 0 and `addr` is unchanged.
- R4: Every payload bit at position 8*`pktLen` or above takes the value of bit 8*`pktLen`-1, and bytes at index `pktLen` or above are ignored. A short packet therefore decodes exactly like its full 9-byte sign-extended form.
- R5: Payload bits 64:2 form a signed field. The byte difference is that field shifted left by one, giving 64 bits with bit 0 equal to 0.
- R6: `notify` is 1 exactly when payload bit 65 differs from bit 64.
- R7: `updiscon` is 1 exactly when payload bit 66 differs from bit 65.
- R8: `irreport` is 1 exactly when payload bit 67 differs from bit 66.
- R9: One cycle after an accepted packet, `valid` pulses for one cycle and `addr` equals the previous stored address plus the difference, modulo 2^64. That value is stored as the new last address.
- R10: When `loadEn` is high, `addr` equals `loadAddr` one cycle later and `valid` and `error` stay 0. A packet presented in the same cycle is discarded.
- R11: In a 9-byte packet, bits 71:68 of the byte string have no effect.
- R12: Bytes fa fb ff ff ff ff ff ff 03 (byte 0 first, length 9) give a difference of -0x204 with notify 0, updiscon 1 and irreport 0. Bytes d6 18 00 00 00 00 00 00 (length 8) give +0xc6a with all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pktValid | input | 1 | A packet is presented this cycle |
| pktBytes | input | 72 | Packet bytes, byte 0 in bits 7:0 |
| pktLen | input | 4 | Number of received bytes |
| loadEn | input | 1 | Set the stored address from `loadAddr` |
| loadAddr | input | 64 | Value to load as the stored address |
| addr | output | 64 | Stored / newly reconstructed absolute address |
| notify | output | 1 | Decoded notify flag of the last accepted packet |
| updiscon | output | 1 | Decoded updiscon flag of the last accepted packet |
| irreport | output | 1 | Decoded irreport flag of the last accepted packet |
| valid | output | 1 | One-cycle pulse: a packet was decoded |
| error | output | 1 | One-cycle pulse: a packet was rejected |

## Verification
The sweep crosses eight even differences with all eight flag combinations. The differences are zero, small positive and negative values, the two example values, 2^62 and the most negative value. Each combination is sent at every length that is a legal compression of its payload, with garbage in the unused bytes. Equal results across lengths separate correct sign-extension from reading absent bytes. The flag patterns separate relative decoding from direct reading of bits 67:65. Differences near the sign boundary show whether the field is treated as signed, and the running sum shows whether it wraps modulo 2^64. Bad format codes and bad lengths, a load alone, and a load colliding with a packet check the paths that leave the stored address alone or replace it.

// File: rtl/trdec_pkg.sv
package trdec_pkg;

  // Format code of a differential-address packet (bits 1:0 of byte 0).
  localparam logic [1:0] FMT_DIFF = 2'b10;

  // Strobes from control to datapath.
  typedef struct packed {
    logic takePkt;   // decode packet and update the stored address
    logic takeLoad;  // overwrite the stored address from the load port
  } trdecStrobe_t;

endpackage

// File: rtl/trdec_ctrl.sv
module trdec_ctrl
  import trdec_pkg::*;
#(
  parameter int MAX_BYTES = 9,
  parameter int LEN_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pktValid,
  input  logic             loadEn,
  input  logic [1:0]       fmtCode,
  input  logic [LEN_W-1:0] pktLen,
  output trdecStrobe_t     strobe,
  output logic             valid,
  output logic             error
);

  logic lenOk;
  logic fmtOk;
  logic fault;

  assign lenOk = (pktLen != '0) && (int'(pktLen) <= MAX_BYTES);
  assign fmtOk = (fmtCode == FMT_DIFF);

  always_comb begin
    strobe          = '0;
    strobe.takeLoad = loadEn;
    strobe.takePkt  = pktValid && !loadEn && lenOk && fmtOk;
  end

  assign fault = pktValid && !loadEn && !(lenOk && fmtOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= 1'b0;
      error <= 1'b0;
    end else begin
      valid <= strobe.takePkt;
      error <= fault;
    end
  end

  // R2: a wrong format code gives an error pulse and no valid
  p_fmt_err_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !loadEn && fmtCode != FMT_DIFF) |=> (error && !valid));

  // R3: a zero length gives an error pulse and no valid
  p_len_err_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !loadEn && pktLen == '0) |=> (error && !valid));

  // R10: a load never produces a valid or an error
  p_load_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (!valid && !error));

endmodule

// File: rtl/trdec_dp.sv
module trdec_dp
  import trdec_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PAY_W     = 68,
  parameter int MAX_BYTES = 9,
  parameter int LEN_W     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  trdecStrobe_t           strobe,
  input  logic [MAX_BYTES*8-1:0] pktBytes,
  input  logic [LEN_W-1:0]       pktLen,
  input  logic [ADDR_W-1:0]      loadAddr,
  output logic [ADDR_W-1:0]      addr,
  output logic                   notify,
  output logic                   updiscon,
  output logic                   irreport
);

  localparam int RAW_W = MAX_BYTES * 8;
  localparam int NB_W  = LEN_W + 3;

  logic [NB_W-1:0]   nBits;
  logic              topBit;
  logic [PAY_W-1:0]  payload;
  logic [ADDR_W-1:0] diff;
  logic [ADDR_W-1:0] newAddr;
  logic [ADDR_W-1:0] lastAddr;

  assign nBits = {pktLen, 3'b000};

  // Last received bit, selected by the byte count.
  always_comb begin
    topBit = pktBytes[RAW_W-1];
    for (int k = 1; k <= MAX_BYTES; k++) begin
      if (pktLen == LEN_W'(k)) topBit = pktBytes[8*k-1];
    end
  end

  // Sign-extension: absent bits repeat the last received bit.
  for (genvar i = 0; i < PAY_W; i++) begin : g_ext
    assign payload[i] = (i < int'(nBits)) ? pktBytes[i] : topBit;
  end

  assign diff    = {payload[ADDR_W:2], 1'b0};
  assign newAddr = lastAddr + diff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddr <= '0;
      notify   <= 1'b0;
      updiscon <= 1'b0;
      irreport <= 1'b0;
    end else if (strobe.takeLoad) begin
      lastAddr <= loadAddr;
    end else if (strobe.takePkt) begin
      lastAddr <= newAddr;
      notify   <= payload[ADDR_W+1] ^ payload[ADDR_W];
      updiscon <= payload[ADDR_W+2] ^ payload[ADDR_W+1];
      irreport <= payload[ADDR_W+3] ^ payload[ADDR_W+2];
    end
  end

  assign addr = lastAddr;

  // R2: without a packet or a load the stored address holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.takePkt && !strobe.takeLoad) |=> $stable(lastAddr));

  // R10: a load puts the load value into the stored address
  p_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeLoad |=> (lastAddr == $past(loadAddr)));

  // R5: the reconstructed step is always even
  p_even_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takePkt |=> (lastAddr[0] == $past(lastAddr[0])));

endmodule

// File: rtl/trace_diff_decoder.sv
module trace_diff_decoder
  import trdec_pkg::*;
#(
  parameter  int ADDR_W    = 64,
  localparam int PAY_W     = ADDR_W + 4,
  localparam int MAX_BYTES = (PAY_W + 7) / 8,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pktValid,
  input  logic [MAX_BYTES*8-1:0] pktBytes,
  input  logic [LEN_W-1:0]       pktLen,
  input  logic                   loadEn,
  input  logic [ADDR_W-1:0]      loadAddr,
  output logic [ADDR_W-1:0]      addr,
  output logic                   notify,
  output logic                   updiscon,
  output logic                   irreport,
  output logic                   valid,
  output logic                   error
);

  trdecStrobe_t strobe;

  trdec_ctrl #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pktValid (pktValid),
    .loadEn   (loadEn),
    .fmtCode  (pktBytes[1:0]),
    .pktLen   (pktLen),
    .strobe   (strobe),
    .valid    (valid),
    .error    (error)
  );

  trdec_dp #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pktBytes (pktBytes),
    .pktLen   (pktLen),
    .loadAddr (loadAddr),
    .addr     (addr),
    .notify   (notify),
    .updiscon (updiscon),
    .irreport (irreport)
  );

endmodule

// File: tb/test_trace_diff_decoder.sv
module test_trace_diff_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic [71:0] pktBytes = '0;
  logic [3:0]  pktLen = '0;
  logic        loadEn = 1'b0;
  logic [63:0] loadAddr = '0;
  logic [63:0] addr;
  logic        notify, updiscon, irreport, valid, error;

  int nChecks = 0;
  int nFail = 0;
  logic [63:0] expAddr = '0;
  logic [63:0] diffs [8];

  always #10 clk = ~clk;

  trace_diff_decoder i_trace_diff_decoder (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktBytes(pktBytes),
    .pktLen(pktLen), .loadEn(loadEn), .loadAddr(loadAddr), .addr(addr),
    .notify(notify), .updiscon(updiscon), .irreport(irreport),
    .valid(valid), .error(error)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [67:0] act, input logic [67:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Full payload built from the requirements (R5..R8), upper nibble zero.
  function automatic logic [71:0] buildFull(input logic [63:0] d, input logic [2:0] fl);
    logic [67:0] p;
    p[1:0]  = 2'b10;
    p[64:2] = d[63:1];
    p[65]   = p[64] ^ fl[0];
    p[66]   = p[65] ^ fl[1];
    p[67]   = p[66] ^ fl[2];
    return {4'h0, p};
  endfunction

  function automatic bit legalLen(input logic [71:0] f, input int len);
    bit ok = 1'b1;
    for (int j = 8 * len; j < 68; j++) if (f[j] != f[8*len-1]) ok = 1'b0;
    return ok;
  endfunction

  task automatic sendPkt(input logic [71:0] raw, input logic [3:0] len);
    @(negedge clk);
    pktValid = 1'b1; pktBytes = raw; pktLen = len;
    @(negedge clk);
    pktValid = 1'b0;
  endtask

  task automatic expectDecode(input string tag, input logic [63:0] d, input logic [2:0] fl);
    expAddr = expAddr + d;
    check(valid == 1'b1 && error == 1'b0, {tag, " R9 valid"}, {66'b0, valid, error}, 68'b10);
    check(addr == expAddr, {tag, " R9 addr"}, {4'b0, addr}, {4'b0, expAddr});
    check({irreport, updiscon, notify} == fl, {tag, " R6 R7 R8 flags"},
          {65'b0, irreport, updiscon, notify}, {65'b0, fl});
  endtask

  task automatic expectReject(input string tag);
    check(error == 1'b1 && valid == 1'b0, {tag, " error"}, {66'b0, valid, error}, 68'b01);
    check(addr == expAddr, {tag, " addr held"}, {4'b0, addr}, {4'b0, expAddr});
  endtask

  task automatic runTests();
    logic [71:0] full, raw;
    diffs[0] = 64'd0;
    diffs[1] = 64'd2;
    diffs[2] = -64'd2;
    diffs[3] = 64'hc6a;
    diffs[4] = -64'h204;
    diffs[5] = 64'h4000_0000_0000_0000;
    diffs[6] = 64'h8000_0000_0000_0000;
    diffs[7] = 64'h0123_4567_89ab_cdee;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(addr == 64'd0, "R1 addr", {4'b0, addr}, 68'd0);
    check({valid, error, notify, updiscon, irreport} == 5'b0, "R1 strobes and flags",
          {63'b0, valid, error, notify, updiscon, irreport}, 68'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R10: load alone
    loadEn = 1'b1; loadAddr = 64'h1000;
    @(negedge clk);
    loadEn = 1'b0;
    expAddr = 64'h1000;
    check(addr == expAddr && !valid && !error, "R10 load", {4'b0, addr}, {4'b0, expAddr});

    // R12: first example, then the same with garbage in bits 71:68 (R11)
    sendPkt(72'h03_ff_ff_ff_ff_ff_ff_fb_fa, 4'd9);
    expectDecode("R12 ex1", -64'h204, 3'b010);
    sendPkt(72'hf3_ff_ff_ff_ff_ff_ff_fb_fa, 4'd9);
    expectDecode("R11 upper nibble", -64'h204, 3'b010);
    // R12: second example, short form and full form (R4)
    sendPkt(72'h00_00_00_00_00_00_00_18_d6, 4'd8);
    expectDecode("R12 ex2 short", 64'hc6a, 3'b000);
    sendPkt(72'h00_00_00_00_00_00_00_18_d6, 4'd9);
    expectDecode("R4 ex2 full", 64'hc6a, 3'b000);

    // R2: wrong format codes
    for (int fc = 0; fc < 4; fc++) begin
      if (fc == 2) continue;
      sendPkt({70'h12345, 2'(fc)}, 4'd3);
      expectReject("R2 format");
    end
    // R3: bad lengths
    sendPkt(72'h0000_0000_0000_0000_06, 4'd0);
    expectReject("R3 len0");
    sendPkt(72'h0000_0000_0000_0000_06, 4'd10);
    expectReject("R3 len10");
    sendPkt(72'h0000_0000_0000_0000_06, 4'd15);
    expectReject("R3 len15");

    // R10: load collides with a packet
    @(negedge clk);
    loadEn = 1'b1; loadAddr = 64'hffff_ffff_ffff_fff0;
    pktValid = 1'b1; pktBytes = 72'h0a; pktLen = 4'd1;
    @(negedge clk);
    loadEn = 1'b0; pktValid = 1'b0;
    expAddr = 64'hffff_ffff_ffff_fff0;
    check(addr == expAddr && !valid && !error, "R10 load wins", {4'b0, addr}, {4'b0, expAddr});

    // R4 R5 R6 R7 R8 R9: sweep differences x flags x legal lengths
    for (int di = 0; di < 8; di++) begin
      for (int fl = 0; fl < 8; fl++) begin
        full = buildFull(diffs[di], 3'(fl));
        for (int len = 1; len <= 9; len++) begin
          if (!legalLen(full, len)) continue;
          raw = full;
          for (int b = len; b < 9; b++) raw[8*b +: 8] = 8'ha5;
          if (len == 9) raw[71:68] = 4'ha;
          sendPkt(raw, 4'(len));
          expectDecode("R4 R5 sweep", diffs[di], 3'(fl));
        end
      end
    end
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nFail++;
        $display("FAIL watchdog: run hung, actual=expired expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule